// File: doc/BRIEF.md
# Serial Data Link Receive Destuffer and Byte Matcher

This block takes the serial maintenance data link carried inside a T1 frame, one bit per strobe from the framer, and turns it into bytes a host can read. An optional zero remover undoes the bit stuffing that HDLC-style links apply. It drops a zero that follows a run of exactly five ones and leaves every other bit alone. Surviving bits are packed least-significant bit first. Each completed byte is latched into a read register and announced by a one-cycle pulse.

Every completed byte is compared against two match values written by the host. A hit sets a sticky status bit. That bit pulls an active-low interrupt if the host has enabled it, and it stays set until the host clears it.

Host registers (8-bit data, 3-bit address, read data registered one cycle after the address):
- Address 0, control: bit 0 enables the zero remover.
- Address 1 and address 2: the two match bytes.
- Address 3, interrupt mask: bit 0 enables the interrupt.
- Address 4, status: bit 0 is the pending match. Writing 1 to it clears it.
- Address 5: the last received byte (read only).

Top module: `fdl_rx_unit`

## Requirements
- R1: With control bit 0 set, a zero that arrives after exactly five consecutive ones is discarded. It does not count toward the eight bits of a byte.
- R2: With control bit 0 set, a zero that arrives after six or more consecutive ones is kept as data. The ones count saturates, so runs of any length behave this way.
- R3: With control bit 0 clear, every strobed bit, zeros after five ones included, is kept as data.
- R4: Kept bits fill the byte least-significant bit first. The byte read at address 5 then updates, and byte_ready pulses high for exactly one cycle per eight kept bits.
- R5: A completed byte equal to the byte at address 1 or the byte at address 2 sets status bit 0 (address 4).
- R6: irq_n is low exactly when status bit 0 and mask bit 0 (address 3) are both set. With mask bit 0 clear, a match leaves irq_n high.
- R7: Status bit 0 stays set through non-matching bytes and through writes of 0. Only a write with bit 0 equal to 1 at address 4 clears it.
- R8: After synchronous reset, all registers read 0, irq_n is high and byte_ready is low.
- R9: bit_in is ignored in cycles where bit_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Strobe marking a valid data link bit |
| bit_in | input | 1 | Serial data link bit |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, one cycle after address |
| byte_ready | output | 1 | One-cycle pulse when a byte completes |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench aims at the boundary between five and six ones. A remover that counts runs wrongly either drops the zero after six ones, corrupting V3/V5, or keeps the zero after five, shifting V2/V6 by one bit. One stream places a stuffed zero mid-byte. A design that still advanced the bit counter on a dropped zero would complete the byte one bit early with a different value. The status tests write 0 to the status register and feed a non-matching byte. A status bit that was not sticky, or that cleared on any write, would lose the pending match and release the interrupt. Masked matches check that irq_n ignores the mask-off case.

// File: rtl/fdl_rx_pkg.sv
package fdl_rx_pkg;
  localparam int REG_AW    = 3;
  localparam int NUM_MATCH = 2;

  localparam logic [REG_AW-1:0] RA_CTRL    = 3'd0;
  localparam logic [REG_AW-1:0] RA_MATCH_A = 3'd1;
  localparam logic [REG_AW-1:0] RA_MATCH_B = 3'd2;
  localparam logic [REG_AW-1:0] RA_MASK    = 3'd3;
  localparam logic [REG_AW-1:0] RA_STATUS  = 3'd4;
  localparam logic [REG_AW-1:0] RA_RXDATA  = 3'd5;
endpackage

// File: rtl/fdl_zero_remover.sv
module fdl_zero_remover #(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic bit_en,
  input  logic bit_in,
  output logic keep_vld,
  output logic keep_bit
);
  localparam int RUN_MAX = STUFF_RUN + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic [RUN_W-1:0] run_q;
  logic             drop;

  // A zero is removed only when the run is exactly STUFF_RUN long.
  assign drop = enable && !bit_in && (run_q == RUN_W'(STUFF_RUN));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= '0;
      keep_vld <= 1'b0;
      keep_bit <= 1'b0;
    end else begin
      keep_vld <= bit_en && !drop;
      if (bit_en) begin
        keep_bit <= bit_in;
        if (!bit_in)
          run_q <= '0;
        else if (run_q != RUN_W'(RUN_MAX))
          run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fdl_byte_packer.sv
module fdl_byte_packer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              in_bit,
  output logic [DATA_W-1:0] byte_q,
  output logic              byte_rdy
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shifted;

  // First bit received ends up in bit 0 after DATA_W shifts.
  assign shifted = {in_bit, shreg[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      cnt_q    <= '0;
      byte_q   <= '0;
      byte_rdy <= 1'b0;
    end else begin
      byte_rdy <= 1'b0;
      if (in_vld) begin
        shreg <= shifted;
        if (cnt_q == CNT_W'(DATA_W - 1)) begin
          cnt_q    <= '0;
          byte_q   <= shifted;
          byte_rdy <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fdl_match_unit.sv
module fdl_match_unit #(
  parameter int DATA_W    = 8,
  parameter int NUM_MATCH = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             byte_rdy,
  input  logic [DATA_W-1:0]                byte_q,
  input  logic [NUM_MATCH-1:0][DATA_W-1:0] match_val,
  output logic                             hit
);
  logic [NUM_MATCH-1:0] eq;

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
    assign eq[i] = (byte_q == match_val[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= byte_rdy && (|eq);
  end
endmodule

// File: rtl/fdl_host_regs.sv
module fdl_host_regs
  import fdl_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             reg_wr,
  input  logic [REG_AW-1:0]                reg_addr,
  input  logic [DATA_W-1:0]                reg_wdata,
  input  logic                             hit,
  input  logic [DATA_W-1:0]                rx_byte,
  output logic [DATA_W-1:0]                reg_rdata,
  output logic                             destuff_en,
  output logic [NUM_MATCH-1:0][DATA_W-1:0] match_val,
  output logic                             pend,
  output logic                             irq_en
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] mask_q;
  logic              clr;

  assign destuff_en = ctrl_q[0];
  assign irq_en     = mask_q[0];
  assign clr        = reg_wr && (reg_addr == RA_STATUS) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      mask_q    <= '0;
      match_val <= '0;
      pend      <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_CTRL:    ctrl_q       <= reg_wdata;
          RA_MATCH_A: match_val[0] <= reg_wdata;
          RA_MATCH_B: match_val[1] <= reg_wdata;
          RA_MASK:    mask_q       <= reg_wdata;
          default:    ;
        endcase
      end
      // A new hit wins over a clear in the same cycle.
      if (hit)      pend <= 1'b1;
      else if (clr) pend <= 1'b0;

      case (reg_addr)
        RA_CTRL:    reg_rdata <= ctrl_q;
        RA_MATCH_A: reg_rdata <= match_val[0];
        RA_MATCH_B: reg_rdata <= match_val[1];
        RA_MASK:    reg_rdata <= mask_q;
        RA_STATUS:  reg_rdata <= {{(DATA_W-1){1'b0}}, pend};
        RA_RXDATA:  reg_rdata <= rx_byte;
        default:    reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/fdl_rx_unit.sv
module fdl_rx_unit
  import fdl_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              byte_ready,
  output logic              irq_n
);
  logic                             destuff_en;
  logic                             keep_vld;
  logic                             keep_bit;
  logic [DATA_W-1:0]                rx_byte;
  logic                             hit;
  logic                             pend;
  logic                             irq_en;
  logic [NUM_MATCH-1:0][DATA_W-1:0] match_val;

  fdl_zero_remover #(.STUFF_RUN(STUFF_RUN)) u_remover (
    .clk(clk), .rst(rst), .enable(destuff_en),
    .bit_en(bit_en), .bit_in(bit_in),
    .keep_vld(keep_vld), .keep_bit(keep_bit)
  );

  fdl_byte_packer #(.DATA_W(DATA_W)) u_packer (
    .clk(clk), .rst(rst), .in_vld(keep_vld), .in_bit(keep_bit),
    .byte_q(rx_byte), .byte_rdy(byte_ready)
  );

  fdl_match_unit #(.DATA_W(DATA_W), .NUM_MATCH(NUM_MATCH)) u_match (
    .clk(clk), .rst(rst), .byte_rdy(byte_ready), .byte_q(rx_byte),
    .match_val(match_val), .hit(hit)
  );

  fdl_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .hit(hit), .rx_byte(rx_byte),
    .reg_rdata(reg_rdata), .destuff_en(destuff_en),
    .match_val(match_val), .pend(pend), .irq_en(irq_en)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= !(pend && irq_en);
  end
endmodule

// File: rtl/fdl_rx_checker.sv
module fdl_rx_checker
  import fdl_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic              bit_in,
  input logic              destuff_en,
  input logic              keep_vld,
  input logic              byte_ready,
  input logic              pend,
  input logic              irq_en,
  input logic              irq_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata
);
  localparam int ONES_W = $clog2(STUFF_RUN + 2);
  logic [ONES_W-1:0] ones;

  always_ff @(posedge clk) begin
    if (rst) ones <= '0;
    else if (bit_en) begin
      if (!bit_in) ones <= '0;
      else if (ones != ONES_W'(STUFF_RUN + 1)) ones <= ones + 1'b1;
    end
  end

  p_drop_r1: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !bit_in && destuff_en && ones == ONES_W'(STUFF_RUN)) |=> !keep_vld);
  p_keep_long_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !bit_in && destuff_en && ones != ONES_W'(STUFF_RUN)) |=> keep_vld);
  p_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !destuff_en) |=> keep_vld);
  p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    byte_ready |=> !byte_ready);
  p_irq_on_r6: assert property (@(posedge clk) disable iff (rst)
    (pend && irq_en) |=> !irq_n);
  p_irq_off_r6: assert property (@(posedge clk) disable iff (rst)
    !(pend && irq_en) |=> irq_n);
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (pend && !(reg_wr && reg_addr == RA_STATUS && reg_wdata[0])) |=> pend);
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> !keep_vld);
endmodule

bind fdl_rx_unit fdl_rx_checker #(.DATA_W(DATA_W), .STUFF_RUN(STUFF_RUN)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
  .destuff_en(destuff_en), .keep_vld(keep_vld), .byte_ready(byte_ready),
  .pend(pend), .irq_en(irq_en), .irq_n(irq_n), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/fdl_rx_unit_test.sv
module fdl_rx_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       byte_ready;
  logic       irq_n;

  int total = 0;
  int bad = 0;
  int rdy_cnt = 0;
  logic [7:0] rd;

  always #10 clk = ~clk;

  fdl_rx_unit uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .byte_ready(byte_ready), .irq_n(irq_n)
  );

  always @(negedge clk) if (byte_ready) rdy_cnt++;

  // {destuff_en, length, stream sent LSB first, expected byte}
  localparam logic [29:0] VEC [8] = '{
    {1'b0, 5'd8, 16'h00A5, 8'hA5},
    {1'b0, 5'd8, 16'h005F, 8'h5F},
    {1'b1, 5'd9, 16'h005F, 8'h3F},
    {1'b1, 5'd8, 16'h00BF, 8'hBF},
    {1'b1, 5'd8, 16'h00FF, 8'hFF},
    {1'b1, 5'd8, 16'h007F, 8'h7F},
    {1'b1, 5'd9, 16'h013E, 8'hBE},
    {1'b0, 5'd8, 16'h0000, 8'h00}
  };
  localparam string VTAG [8] = '{"R3/R4", "R3", "R1", "R2", "R2", "R2", "R1", "R4"};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rdy_cnt = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic send(input logic [15:0] s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_en = 1'b1; bit_in = s[i];
    end
    @(negedge clk); bit_en = 1'b0; bit_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Vector table walk
    for (int v = 0; v < 8; v++) begin
      do_reset();
      wr(3'd0, {7'd0, VEC[v][29]});
      send(VEC[v][23:8], int'(VEC[v][28:24]));
      check({VTAG[v], " byte count"}, rdy_cnt, 1);
      rdreg(3'd5, rd);
      check({VTAG[v], " byte value"}, rd, VEC[v][7:0]);
    end

    // R8 reset state
    do_reset();
    @(negedge clk);
    check("R8 irq_n", irq_n, 1);
    check("R8 byte_ready", byte_ready, 0);
    for (int a = 0; a < 6; a++) begin
      rdreg(3'(a), rd);
      check("R8 register zero", rd, 0);
    end

    // R9 bit_in ignored without bit_en
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); bit_in = ~bit_in;
    end
    bit_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 no byte while idle", rdy_cnt, 0);
    send(16'h0081, 8);
    rdreg(3'd5, rd);
    check("R9 alignment kept", rd, 8'h81);

    // R5/R6 match with mask off, then on
    wr(3'd1, 8'h5A);
    wr(3'd2, 8'hC3);
    send(16'h00C3, 8);
    rdreg(3'd4, rd);
    check("R5 match B sets status", rd, 1);
    check("R6 masked irq_n high", irq_n, 1);
    wr(3'd3, 8'h01);
    repeat (3) @(negedge clk);
    check("R6 enabled irq_n low", irq_n, 0);

    // R7 sticky status
    wr(3'd4, 8'h00);
    send(16'h0011, 8);
    rdreg(3'd4, rd);
    check("R7 status survives write 0 and miss", rd, 1);
    check("R7 irq_n still low", irq_n, 0);
    wr(3'd4, 8'h01);
    repeat (3) @(negedge clk);
    rdreg(3'd4, rd);
    check("R7 status cleared", rd, 0);
    check("R6 irq_n released", irq_n, 1);

    // R5 match A
    send(16'h005A, 8);
    rdreg(3'd4, rd);
    check("R5 match A sets status", rd, 1);
    check("R6 irq_n low on match A", irq_n, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule